// File: doc/BRIEF.md
# Dual-Channel Periodic Time-Base Interrupt Generator

This block produces periodic interrupt requests for a processor core from two independent channels. Each channel chooses a prescaler tick source: the system clock itself, a divide-by-four tick from the system clock, or rising edges of a slow asynchronous sub-clock. A per-channel counter divides that tick by a power of two between 2^8 and 2^15, set by a 3-bit exponent. Each overflow sets the channel's request flag.

A request reaches the core only when several conditions hold at once. The global enable must be set, the channel enable must be set, and the processor's stack must not be full. When the core acknowledges a request, the block clears the presented channel's flag and also drops the global enable. Further interrupts stay blocked until software sets the global enable again. Channel 0 wins when both channels are pending. Software can clear a flag directly, but a hardware set in the same cycle takes precedence.

The block runs entirely on the system clock and uses a synchronous, active-high reset. The sub-clock is brought in through a synchroniser and turned into single-cycle ticks.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset, both request flags, the global enable and the interrupt output are 0, and both counters are held at zero.
- R2: The 2-bit source field of a channel selects its counter tick: 00 means every system cycle, 01 means one system cycle in four, and 10 or 11 means one tick per rising edge of the sub-clock.
- R3: With divider exponent N, a running channel sets its flag once every 2^(8+N) ticks. With source 00, the first flag appears exactly 2^(8+N) cycles after the clock edge at which the on bit is first sampled high.
- R4: While a channel's on bit is low its counter is held at zero and its flag is not set. Switching the channel back on starts a full period.
- R5: A change to a channel's source or divider field restarts its counter, so the next flag comes a full new period after the edge at which the change is sampled.
- R6: The two channels count and flag independently of each other.
- R7: `irq_o` is high exactly when the global enable, a channel enable and that channel's flag are all set and `stack_full_i` is low. It reflects input changes one cycle after they are sampled.
- R8: An acknowledge pulse while `irq_o` is high clears the flag of the channel shown on `irq_id_o` and clears the global enable. An acknowledge while `irq_o` is low changes nothing.
- R9: When both channels are eligible, `irq_id_o` shows 0. Channel 1's flag stays set after channel 0 is acknowledged, and channel 1 is presented once the global enable is set again.
- R10: A pulse on a channel's flag-clear input clears its flag on the next edge, unless an overflow sets the flag on that same edge, in which case the flag ends up set.
- R11: A pulse on `gie_set_i` sets the global enable. If an acknowledge arrives on the same edge, the acknowledge wins and the enable ends up cleared.

Ports are listed in port-list order; channel c occupies bits [2c+1:2c] of the source vector and [3c+2:3c] of the divider vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_clk_i | input | 1 | Asynchronous slow sub-clock |
| ch_on_i | input | 2 | Per-channel on bit |
| ch_src_i | input | 4 | Per-channel 2-bit tick source select |
| ch_div_i | input | 6 | Per-channel 3-bit period exponent N |
| ch_en_i | input | 2 | Per-channel interrupt enable |
| flag_clr_i | input | 2 | Per-channel software flag clear pulse |
| gie_set_i | input | 1 | Pulse that sets the global enable |
| stack_full_i | input | 1 | Stack-full indication from the core |
| irq_ack_i | input | 1 | Acknowledge of the presented request |
| irq_o | output | 1 | Interrupt request to the core |
| irq_id_o | output | 1 | Channel number of the presented request |
| flag_o | output | 2 | Per-channel request flags |
| gie_o | output | 1 | Global interrupt enable state |

## Verification
A counter that starts from a stale value or misses a restart shows up as a flag that rises a wrong number of cycles after the on edge or a configuration change. The bench measures this edge-exactly for the system-clock source, and as exact flag-to-flag intervals for the divided and sub-clock sources. A wrongly held flag or global enable shows up at `irq_o` and `flag_o` one edge after the acknowledge or clear. A priority fault shows as the wrong `irq_id_o` on the first cycle both channels are eligible.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  typedef enum logic [1:0] {
    SRC_SYS     = 2'b00,
    SRC_QUARTER = 2'b01,
    SRC_SLOW    = 2'b10,
    SRC_SLOW_B  = 2'b11
  } src_sel_e;

  // Chooses the counting tick for one channel from the three candidates.
  function automatic logic pick_tick(input logic [1:0] sel,
                                     input logic quarter_tick,
                                     input logic slow_tick);
    logic t;
    case (src_sel_e'(sel))
      SRC_SYS:     t = 1'b1;
      SRC_QUARTER: t = quarter_tick;
      default:     t = slow_tick;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/tbase_tick_gen.sv
module tbase_tick_gen #(
  parameter int PRE_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sub_clk_i,
  output logic quarter_tick_o,
  output logic slow_tick_o
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0]          pre_cnt_q;
  logic                   quarter_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   slow_q;

  // Free-running pre-divider on the system clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt_q <= '0;
      quarter_q <= 1'b0;
    end else begin
      pre_cnt_q <= (pre_cnt_q == PRE_LAST) ? '0 : pre_cnt_q + 1'b1;
      quarter_q <= (pre_cnt_q == PRE_LAST);
    end
  end

  // Synchroniser chain for the slow clock, then rising-edge detection.
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sub_clk_i};
      prev_q <= sync_q[SYNC_STAGES-1];
      slow_q <= sync_q[SYNC_STAGES-1] & ~prev_q;
    end
  end

  assign quarter_tick_o = quarter_q;
  assign slow_tick_o    = slow_q;

  // R2
  quarter_gap_chk: assert property (@(posedge clk) disable iff (rst)
    quarter_q |=> !quarter_q);

  // R2
  slow_single_chk: assert property (@(posedge clk) disable iff (rst)
    slow_q |=> !slow_q);

endmodule

// File: rtl/tbase_channel.sv
module tbase_channel
  import tbase_pkg::*;
#(
  parameter int BASE_EXP = 8,
  parameter int DIV_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             on_i,
  input  logic [1:0]       src_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             quarter_tick_i,
  input  logic             slow_tick_i,
  input  logic             clr_i,
  input  logic             ack_i,
  output logic             flag_o,
  output logic             flag_nxt_o
);
  localparam int MAX_N = (1 << DIV_W) - 1;
  localparam int CNT_W = BASE_EXP + MAX_N;
  localparam int CFG_W = 1 + 2 + DIV_W;
  localparam logic [CNT_W-1:0] ONES = '1;

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_now;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;
  logic [DIV_W-1:0] shift_amt;
  logic             flag_q;
  logic             restart;
  logic             tick;
  logic             ovf;

  assign cfg_now   = {on_i, src_i, div_i};
  // Any change of configuration, or the channel being off, restarts the count.
  assign restart   = (cfg_now != cfg_q) || !cfg_q[CFG_W-1];
  assign tick      = pick_tick(cfg_q[DIV_W+1:DIV_W], quarter_tick_i, slow_tick_i);
  assign shift_amt = DIV_W'(MAX_N) - cfg_q[DIV_W-1:0];
  assign last_val  = ONES >> shift_amt;
  assign ovf       = !restart && tick && (cnt_q == last_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      cfg_q <= cfg_now;
      if (restart)   cnt_q <= '0;
      else if (ovf)  cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  // Hardware set outranks both software clear and acknowledge.
  always_comb begin
    if (ovf)                flag_nxt_o = 1'b1;
    else if (clr_i || ack_i) flag_nxt_o = 1'b0;
    else                    flag_nxt_o = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_nxt_o;
  end

  assign flag_o = flag_q;

  // R4
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !on_i |=> (cnt_q == '0));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_val);

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |=> flag_q);

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i && !ack_i) |=> flag_q);

endmodule

// File: rtl/tbase_irq_arb.sv
module tbase_irq_arb #(
  parameter int NCH = 2,
  parameter int IDW = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] flag_nxt_i,
  input  logic [NCH-1:0] en_i,
  input  logic           gie_nxt_i,
  input  logic           stall_i,
  output logic           irq_o,
  output logic [IDW-1:0] id_o
);
  logic [NCH-1:0] elig;
  logic [IDW-1:0] pick;
  logic           irq_q;
  logic [IDW-1:0] id_q;

  assign elig = flag_nxt_i & en_i;

  // Lowest channel number wins.
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i]) pick = IDW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      id_q  <= '0;
    end else begin
      irq_q <= gie_nxt_i && !stall_i && (|elig);
      if (|elig) id_q <= pick;
    end
  end

  assign irq_o = irq_q;
  assign id_o  = id_q;

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> !irq_q);

endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen #(
  parameter int NCH         = 2,
  parameter int BASE_EXP    = 8,
  parameter int DIV_W       = 3,
  parameter int PRE_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sub_clk_i,
  input  logic [NCH-1:0]           ch_on_i,
  input  logic [2*NCH-1:0]         ch_src_i,
  input  logic [DIV_W*NCH-1:0]     ch_div_i,
  input  logic [NCH-1:0]           ch_en_i,
  input  logic [NCH-1:0]           flag_clr_i,
  input  logic                     gie_set_i,
  input  logic                     stack_full_i,
  input  logic                     irq_ack_i,
  output logic                     irq_o,
  output logic [((NCH>1)?$clog2(NCH):1)-1:0] irq_id_o,
  output logic [NCH-1:0]           flag_o,
  output logic                     gie_o
);
  localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1;

  logic           quarter_tick;
  logic           slow_tick;
  logic [NCH-1:0] flag_nxt;
  logic [NCH-1:0] ack_ch;
  logic           ack_fire;
  logic           gie_q;
  logic           gie_nxt;

  tbase_tick_gen #(
    .PRE_DIV     (PRE_DIV),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ticks (
    .clk            (clk),
    .rst            (rst),
    .sub_clk_i      (sub_clk_i),
    .quarter_tick_o (quarter_tick),
    .slow_tick_o    (slow_tick)
  );

  assign ack_fire = irq_ack_i && irq_o;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign ack_ch[c] = ack_fire && (irq_id_o == IDW'(c));

      tbase_channel #(
        .BASE_EXP (BASE_EXP),
        .DIV_W    (DIV_W)
      ) u_ch (
        .clk            (clk),
        .rst            (rst),
        .on_i           (ch_on_i[c]),
        .src_i          (ch_src_i[2*c +: 2]),
        .div_i          (ch_div_i[DIV_W*c +: DIV_W]),
        .quarter_tick_i (quarter_tick),
        .slow_tick_i    (slow_tick),
        .clr_i          (flag_clr_i[c]),
        .ack_i          (ack_ch[c]),
        .flag_o         (flag_o[c]),
        .flag_nxt_o     (flag_nxt[c])
      );
    end
  endgenerate

  // Acknowledge outranks a same-cycle set of the global enable.
  always_comb begin
    if (ack_fire)       gie_nxt = 1'b0;
    else if (gie_set_i) gie_nxt = 1'b1;
    else                gie_nxt = gie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) gie_q <= 1'b0;
    else     gie_q <= gie_nxt;
  end

  assign gie_o = gie_q;

  tbase_irq_arb #(
    .NCH (NCH),
    .IDW (IDW)
  ) u_arb (
    .clk        (clk),
    .rst        (rst),
    .flag_nxt_i (flag_nxt),
    .en_i       (ch_en_i),
    .gie_nxt_i  (gie_nxt),
    .stall_i    (stack_full_i),
    .irq_o      (irq_o),
    .id_o       (irq_id_o)
  );

  // R8
  ack_drops_gie_chk: assert property (@(posedge clk) disable iff (rst)
    ack_fire |=> !gie_o);

  // R7
  irq_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> gie_o);

  // R9
  irq_flag_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o[irq_id_o]);

  // R11
  gie_set_chk: assert property (@(posedge clk) disable iff (rst)
    (gie_set_i && !ack_fire) |=> gie_o);

endmodule

// File: tb/test_periodic_irq_gen.sv
module test_periodic_irq_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sub_clk = 1'b0;
  logic [1:0] on = '0;
  logic [3:0] src = '0;
  logic [5:0] dv = '0;
  logic [1:0] ch_en = '0;
  logic [1:0] clr = '0;
  logic       gie_set = 1'b0;
  logic       stack_full = 1'b0;
  logic       ack = 1'b0;
  logic       irq;
  logic [0:0] id;
  logic [1:0] flag;
  logic       gie;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;
  initial begin
    #3;
    forever #16 sub_clk = ~sub_clk;
  end

  periodic_irq_gen i_periodic_irq_gen (
    .clk          (clk),
    .rst          (rst),
    .sub_clk_i    (sub_clk),
    .ch_on_i      (on),
    .ch_src_i     (src),
    .ch_div_i     (dv),
    .ch_en_i      (ch_en),
    .flag_clr_i   (clr),
    .gie_set_i    (gie_set),
    .stack_full_i (stack_full),
    .irq_ack_i    (ack),
    .irq_o        (irq),
    .irq_id_o     (id),
    .flag_o       (flag),
    .gie_o        (gie)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk);
    #1;
  endtask

  task automatic measure(input int ch, input int limit, output int n);
    n = 0;
    do begin
      edge1();
      n++;
    end while (!flag[ch] && n < limit);
  endtask

  task automatic clr_measure(input int ch, input int limit, output int n);
    clr[ch] = 1'b1;
    edge1();
    clr[ch] = 1'b0;
    n = 1;
    while (!flag[ch] && n < limit) begin
      edge1();
      n++;
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    on = '0; ch_en = '0; ack = 1'b0; gie_set = 1'b0; stack_full = 1'b0;
    clr = 2'b11;
    edge1();
    clr = '0;
    // Acknowledge path is the only way to drop the global enable.
    edge1();
  endtask

  task automatic t_reset();
    chk(flag == 2'b00, "R1 flags after reset", flag, 0);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    chk(gie == 1'b0, "R1 gie after reset", gie, 0);
  endtask

  task automatic t_period_sys();
    int n;
    go_idle();
    @(negedge clk);
    src[1:0] = 2'b00; dv[2:0] = 3'd0; on[0] = 1'b1;
    measure(0, 5000, n);
    chk(n == 257, "R3 first period N=0", n - 1, 256);
    clr_measure(0, 5000, n);
    chk(n == 256, "R3 repeat period N=0", n, 256);
    go_idle();
    @(negedge clk);
    dv[2:0] = 3'd3; on[0] = 1'b1;
    measure(0, 5000, n);
    chk(n == 2049, "R3 first period N=3", n - 1, 2048);
  endtask

  task automatic t_div4();
    int n;
    go_idle();
    @(negedge clk);
    src[1:0] = 2'b01; dv[2:0] = 3'd0; on[0] = 1'b1;
    measure(0, 5000, n);
    clr_measure(0, 5000, n);
    chk(n == 1024, "R2 quarter-rate period", n, 1024);
  endtask

  task automatic t_sub(input logic [1:0] s);
    int n;
    go_idle();
    @(negedge clk);
    src[1:0] = s; dv[2:0] = 3'd0; on[0] = 1'b1;
    measure(0, 8000, n);
    clr_measure(0, 8000, n);
    chk(n == 2048, "R2 sub-clock period", n, 2048);
  endtask

  task automatic t_restart();
    int n;
    go_idle();
    @(negedge clk);
    src[1:0] = 2'b00; dv[2:0] = 3'd2; on[0] = 1'b1;
    repeat (300) @(negedge clk);
    dv[2:0] = 3'd0;
    measure(0, 5000, n);
    chk(n == 257, "R5 restart on divider change", n - 1, 256);
    go_idle();
    @(negedge clk);
    dv[2:0] = 3'd1; src[1:0] = 2'b01; on[0] = 1'b1;
    repeat (100) @(negedge clk);
    src[1:0] = 2'b00;
    measure(0, 5000, n);
    chk(n == 513, "R5 restart on source change", n - 1, 512);
    go_idle();
    @(negedge clk);
    dv[2:0] = 3'd0; on[0] = 1'b1;
    repeat (200) @(negedge clk);
    on[0] = 1'b0;
    repeat (300) @(negedge clk);
    chk(flag[0] == 1'b0, "R4 no flag while off", flag[0], 0);
    on[0] = 1'b1;
    measure(0, 5000, n);
    chk(n == 257, "R4 full period after re-enable", n - 1, 256);
  endtask

  task automatic t_indep();
    int n;
    go_idle();
    @(negedge clk);
    src = 4'b0000; dv = {3'd1, 3'd0}; on = 2'b11;
    measure(0, 5000, n);
    chk(n == 257, "R6 ch0 period beside ch1", n - 1, 256);
    chk(flag[1] == 1'b0, "R6 ch1 not yet set", flag[1], 0);
    measure(1, 5000, n);
    chk(n == 256, "R6 ch1 own period", n + 256, 512);
  endtask

  // Leaves ch0 flagged and channel stopped.
  task automatic arm_ch0();
    int n;
    go_idle();
    @(negedge clk);
    src[1:0] = 2'b00; dv[2:0] = 3'd0; on[0] = 1'b1;
    measure(0, 5000, n);
    on[0] = 1'b0;
  endtask

  task automatic t_gate_ack();
    arm_ch0();
    ch_en[0] = 1'b1;
    edge1();
    chk(irq == 1'b0, "R7 no irq without gie", irq, 0);
    gie_set = 1'b1;
    edge1();
    gie_set = 1'b0;
    chk(gie == 1'b1, "R11 gie set", gie, 1);
    chk(irq == 1'b1 && id == 1'b0, "R7 irq when all enabled", irq, 1);
    stack_full = 1'b1;
    edge1();
    chk(irq == 1'b0, "R7 stack full blocks", irq, 0);
    stack_full = 1'b0;
    edge1();
    chk(irq == 1'b1, "R7 irq after stack frees", irq, 1);
    ch_en[0] = 1'b0;
    edge1();
    chk(irq == 1'b0, "R7 channel enable blocks", irq, 0);
    ch_en[0] = 1'b1;
    edge1();
    ack = 1'b1;
    edge1();
    ack = 1'b0;
    chk(flag[0] == 1'b0, "R8 ack clears flag", flag[0], 0);
    chk(gie == 1'b0, "R8 ack clears gie", gie, 0);
    chk(irq == 1'b0, "R8 irq drops after ack", irq, 0);
    arm_ch0();
    ch_en[0] = 1'b1;
    ack = 1'b1;
    edge1();
    ack = 1'b0;
    chk(flag[0] == 1'b1, "R8 stray ack ignored", flag[0], 1);
    gie_set = 1'b1;
    edge1();
    gie_set = 1'b1; ack = 1'b1;
    edge1();
    gie_set = 1'b0; ack = 1'b0;
    chk(gie == 1'b0, "R11 ack beats gie set", gie, 0);
  endtask

  task automatic t_prio();
    int n;
    go_idle();
    @(negedge clk);
    src = 4'b0000; dv = 6'd0; on = 2'b11;
    measure(0, 5000, n);
    on = 2'b00;
    ch_en = 2'b11; gie_set = 1'b1;
    edge1();
    gie_set = 1'b0;
    chk(irq == 1'b1 && id == 1'b0, "R9 channel 0 first", id, 0);
    ack = 1'b1;
    edge1();
    ack = 1'b0;
    chk(flag == 2'b10, "R9 ch1 still pending", flag, 2);
    chk(irq == 1'b0, "R9 blocked until gie", irq, 0);
    gie_set = 1'b1;
    edge1();
    gie_set = 1'b0;
    chk(irq == 1'b1 && id == 1'b1, "R9 ch1 presented", id, 1);
    ack = 1'b1;
    edge1();
    ack = 1'b0;
    chk(flag == 2'b00, "R8 ch1 ack clears", flag, 0);
  endtask

  task automatic t_swclr();
    int n;
    go_idle();
    @(negedge clk);
    src[1:0] = 2'b00; dv[2:0] = 3'd0; on[0] = 1'b1;
    measure(0, 5000, n);
    clr[0] = 1'b1;
    edge1();
    clr[0] = 1'b0;
    chk(flag[0] == 1'b0, "R10 software clear", flag[0], 0);
    repeat (254) edge1();
    clr[0] = 1'b1;
    edge1();
    chk(flag[0] == 1'b1, "R10 set beats clear", flag[0], 1);
    edge1();
    clr[0] = 1'b0;
    chk(flag[0] == 1'b0, "R10 clear after set", flag[0], 0);
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    rst = 1'b0;
    edge1();
    t_reset();
    t_period_sys();
    t_div4();
    t_sub(2'b10);
    t_sub(2'b11);
    t_restart();
    t_indep();
    t_gate_ack();
    t_prio();
    t_swclr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule